// File: doc/BRIEF.md
# Cache-Block Zero Store Sequencer

This block carries out a cache-block zero operation for a core with machine, supervisor and user privilege levels and an optional virtualized mode. A request brings a target address, the current privilege, a virtualization flag, a region-type flag and three enable bits, one from each environment-configuration level. The block first settles whether the operation traps. If it traps, the block reports one cause code and touches no memory.

If there is no trap, the block clears the low address bits to reach the start of the enclosing block. It then asks a permission probe whether that block may be stored to. If the probe grants the store, the block writes zeros over a valid/ready write port until every byte of the block is cleared. It writes a full word per beat on cacheable memory and one byte per beat on I/O regions. A probe fault ends the operation with a store access fault.

Each operation ends in exactly one outcome: a one-cycle done pulse, or a one-cycle exception pulse with a cause. While an operation is in flight, new requests are not accepted.

Top module: `cbz_store_seq`

## Requirements
- R1: Privilege encoding is user=0, supervisor=1, machine=3. When privilege is not machine and the machine enable bit is 0, the operation traps with cause 2 (illegal instruction). This check has the highest priority.
- R2: If R1 does not apply and virtualization is 1, the operation traps with cause 22 (virtual instruction) when either of two conditions holds: privilege is 1 or lower and the hypervisor enable bit is 0, or privilege is 0 and the supervisor enable bit is 0.
- R3: If R1 and R2 do not apply, virtualization is 0, privilege is 0 and the supervisor enable bit is 0, the operation traps with cause 2.
- R4: In every other case the operation does not trap. It goes on to the probe and then to the writes.
- R5: A trap is reported with exc_valid for one cycle, starting in the cycle after the request is accepted. No probe and no write is issued for a trapping request, and done does not pulse.
- R6: Before any write, probe_valid is raised with probe_addr equal to the request address with its log2(BLOCK_BYTES) low bits cleared. probe_valid and probe_addr stay steady until probe_resp is 1.
- R7: If probe_fault is 1 when probe_resp is 1, the operation ends with exc_valid and cause 7 (store access fault), and no write is issued.
- R8: When req_io is 0, the block issues BLOCK_BYTES/WORD_BYTES writes. Their addresses are base + k*WORD_BYTES, in ascending order. Every write has all bits of wr_strb set and wr_data equal to 0. Each write holds its address until wr_ready is 1.
- R9: When req_io is 1, the block issues BLOCK_BYTES single-byte writes at base + k, in ascending order. Each wr_strb is one-hot, with bit (address mod WORD_BYTES) set, and wr_data is 0.
- R10: done pulses for one cycle, in the cycle after the last write is accepted. In that cycle busy is already 0.
- R11: While busy is 1, req_valid is ignored: it causes no exception, and the running write sequence keeps its addresses and its write count.
- R12: After reset, busy, probe_valid, wr_valid, done and exc_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_addr | input | AW | Target address |
| req_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| req_virt | input | 1 | Virtualization active |
| req_io | input | 1 | Target is a non-cacheable I/O region (byte writes) |
| cfg_m_en | input | 1 | Machine-level enable bit for the operation |
| cfg_h_en | input | 1 | Hypervisor-level enable bit |
| cfg_s_en | input | 1 | Supervisor-level enable bit |
| busy | output | 1 | Operation in flight |
| probe_valid | output | 1 | Store-permission probe request |
| probe_addr | output | AW | Aligned block base being probed |
| probe_resp | input | 1 | Probe result valid |
| probe_fault | input | 1 | Probe denies the store |
| wr_valid | output | 1 | Zero-write request |
| wr_addr | output | AW | Write address |
| wr_strb | output | WORD_BYTES | Byte lanes written |
| wr_data | output | 8*WORD_BYTES | Write data (always zero) |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | One-cycle success pulse |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 5 | Exception cause code |

## Verification
The bench sweeps all enable-bit combinations across each privilege level, with and without virtualization, so that it can catch a priority error. One example is a design that raises cause 22 where the machine enable bit should win, or one that reports cause 2 in virtual mode. It also uses unaligned addresses to expose a wrong alignment mask, and it stalls wr_ready at random to catch an address that advances without a handshake. I/O-region runs check the one-hot byte lane and the count of 64 beats, which a design that kept word writes would get wrong. Probe faults must leave the write count at zero. A trapping request raised partway through a write sequence catches a design that accepts work while busy.

// File: rtl/cbz_pkg.sv
`timescale 1ns/1ps
package cbz_pkg;
   localparam logic [1:0] PRIV_USER  = 2'd0;
   localparam logic [1:0] PRIV_SUPER = 2'd1;
   localparam logic [1:0] PRIV_MACH  = 2'd3;

   localparam int CAUSE_W = 5;
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 5'd2;
   localparam logic [CAUSE_W-1:0] CAUSE_STORE_FAULT = 5'd7;
   localparam logic [CAUSE_W-1:0] CAUSE_VIRT_INSN   = 5'd22;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROBE = 2'd1,
      ST_WRITE = 2'd2
   } cbz_state_e;
endpackage

// File: rtl/cbz_trap_check.sv
`timescale 1ns/1ps
module cbz_trap_check
   import cbz_pkg::*;
(
   input  logic [1:0]         priv,
   input  logic               virt,
   input  logic               m_en,
   input  logic               h_en,
   input  logic               s_en,
   output logic               trap,
   output logic [CAUSE_W-1:0] cause
);
   logic below_mach, at_most_super, below_super;
   logic tier_mach, tier_virt, tier_super;

   assign below_mach    = (priv != PRIV_MACH);
   assign at_most_super = (priv <= PRIV_SUPER);
   assign below_super   = (priv == PRIV_USER);

   assign tier_mach  = below_mach && !m_en;
   assign tier_virt  = virt && ((at_most_super && !h_en) || (below_super && !s_en));
   assign tier_super = !virt && below_super && !s_en;

   always_comb begin
      trap  = 1'b0;
      cause = '0;
      if (tier_mach) begin
         trap  = 1'b1;
         cause = CAUSE_ILLEGAL;
      end else if (tier_virt) begin
         trap  = 1'b1;
         cause = CAUSE_VIRT_INSN;
      end else if (tier_super) begin
         trap  = 1'b1;
         cause = CAUSE_ILLEGAL;
      end
   end

   // R1: a machine-tier hit never reports the virtual-instruction code
   always_comb begin
      if (tier_mach) begin
         a_mach_first_r1: assert (cause == CAUSE_ILLEGAL);
      end
   end
endmodule

// File: rtl/cbz_lane_strobe.sv
`timescale 1ns/1ps
module cbz_lane_strobe #(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 8
) (
   input  logic                  byte_mode,
   input  logic [AW-1:0]         addr,
   output logic [WORD_BYTES-1:0] strb
);
   localparam int LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   generate
      if (WORD_BYTES == 1) begin : g_single_lane
         assign strb = 1'b1;
      end else begin : g_multi_lane
         logic [LANE_W-1:0] lane;
         assign lane = addr[LANE_W-1:0];
         always_comb begin
            strb = '1;
            if (byte_mode) begin
               strb       = '0;
               strb[lane] = 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cbz_seq_ctrl.sv
`timescale 1ns/1ps
module cbz_seq_ctrl
   import cbz_pkg::*;
#(
   parameter int AW          = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int WORD_BYTES  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_base,
   input  logic               req_io,
   input  logic               trap,
   input  logic [CAUSE_W-1:0] trap_cause,
   output logic               busy,
   output logic               probe_valid,
   output logic [AW-1:0]      probe_addr,
   input  logic               probe_resp,
   input  logic               probe_fault,
   output logic               wr_valid,
   output logic [AW-1:0]      wr_addr,
   output logic               wr_byte_mode,
   input  logic               wr_ready,
   output logic               done,
   output logic               exc_valid,
   output logic [CAUSE_W-1:0] exc_cause
);
   localparam int OFFW = $clog2(BLOCK_BYTES);
   localparam int CW   = OFFW + 1;
   localparam logic [CW-1:0] WORD_STEP = CW'(WORD_BYTES);
   localparam logic [CW-1:0] BLK_END   = CW'(BLOCK_BYTES);

   cbz_state_e    state;
   logic [AW-1:0] base_q;
   logic          io_q;
   logic [CW-1:0] off_q;
   logic [CW-1:0] step;
   logic          last_beat;

   assign step      = io_q ? CW'(1) : WORD_STEP;
   assign last_beat = (off_q + step) == BLK_END;

   assign busy         = (state != ST_IDLE);
   assign probe_valid  = (state == ST_PROBE);
   assign probe_addr   = base_q;
   assign wr_valid     = (state == ST_WRITE);
   assign wr_addr      = base_q | {{(AW-OFFW){1'b0}}, off_q[OFFW-1:0]};
   assign wr_byte_mode = io_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         base_q    <= '0;
         io_q      <= 1'b0;
         off_q     <= '0;
         done      <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= '0;
      end else begin
         done      <= 1'b0;
         exc_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (trap) begin
                     exc_valid <= 1'b1;
                     exc_cause <= trap_cause;
                  end else begin
                     state  <= ST_PROBE;
                     base_q <= req_base;
                     io_q   <= req_io;
                     off_q  <= '0;
                  end
               end
            end
            ST_PROBE: begin
               if (probe_resp) begin
                  if (probe_fault) begin
                     exc_valid <= 1'b1;
                     exc_cause <= CAUSE_STORE_FAULT;
                     state     <= ST_IDLE;
                  end else begin
                     state <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_ready) begin
                  if (last_beat) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     off_q <= off_q + step;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_outcome_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && exc_valid));
   p_probe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid && !probe_resp |=> probe_valid && $stable(probe_addr));
   p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid && probe_resp && probe_fault |=> !wr_valid);
   p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_trap_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && (exc_cause != CAUSE_STORE_FAULT) |-> !$past(busy));
endmodule

// File: rtl/cbz_store_seq.sv
`timescale 1ns/1ps
module cbz_store_seq
   import cbz_pkg::*;
#(
   parameter int AW          = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int WORD_BYTES  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [AW-1:0]           req_addr,
   input  logic [1:0]              req_priv,
   input  logic                    req_virt,
   input  logic                    req_io,
   input  logic                    cfg_m_en,
   input  logic                    cfg_h_en,
   input  logic                    cfg_s_en,
   output logic                    busy,
   output logic                    probe_valid,
   output logic [AW-1:0]           probe_addr,
   input  logic                    probe_resp,
   input  logic                    probe_fault,
   output logic                    wr_valid,
   output logic [AW-1:0]           wr_addr,
   output logic [WORD_BYTES-1:0]   wr_strb,
   output logic [8*WORD_BYTES-1:0] wr_data,
   input  logic                    wr_ready,
   output logic                    done,
   output logic                    exc_valid,
   output logic [4:0]              exc_cause
);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BLOCK_BYTES - 1);

   generate
      if (BLOCK_BYTES < 1 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (WORD_BYTES > BLOCK_BYTES) begin : g_word_too_wide
         $error("WORD_BYTES may not exceed BLOCK_BYTES");
      end
      if (AW <= $clog2(BLOCK_BYTES)) begin : g_addr_too_narrow
         $error("AW must exceed log2(BLOCK_BYTES)");
      end
   endgenerate

   logic               trap;
   logic [CAUSE_W-1:0] trap_cause;
   logic               byte_mode;
   logic [AW-1:0]      aligned_base;

   assign aligned_base = req_addr & ALIGN_MASK;
   assign wr_data      = '0;

   cbz_trap_check u_trap (
      .priv  (req_priv),
      .virt  (req_virt),
      .m_en  (cfg_m_en),
      .h_en  (cfg_h_en),
      .s_en  (cfg_s_en),
      .trap  (trap),
      .cause (trap_cause)
   );

   cbz_seq_ctrl #(
      .AW          (AW),
      .BLOCK_BYTES (BLOCK_BYTES),
      .WORD_BYTES  (WORD_BYTES)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_base     (aligned_base),
      .req_io       (req_io),
      .trap         (trap),
      .trap_cause   (trap_cause),
      .busy         (busy),
      .probe_valid  (probe_valid),
      .probe_addr   (probe_addr),
      .probe_resp   (probe_resp),
      .probe_fault  (probe_fault),
      .wr_valid     (wr_valid),
      .wr_addr      (wr_addr),
      .wr_byte_mode (byte_mode),
      .wr_ready     (wr_ready),
      .done         (done),
      .exc_valid    (exc_valid),
      .exc_cause    (exc_cause)
   );

   cbz_lane_strobe #(
      .AW         (AW),
      .WORD_BYTES (WORD_BYTES)
   ) u_strb (
      .byte_mode (byte_mode),
      .addr      (wr_addr),
      .strb      (wr_strb)
   );

   p_cause_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_cause == CAUSE_ILLEGAL) || (exc_cause == CAUSE_VIRT_INSN)
                    || (exc_cause == CAUSE_STORE_FAULT));
   p_probe_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> (probe_addr & ~ALIGN_MASK) == '0);
   p_write_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr & ALIGN_MASK) == probe_addr);
   p_strobe_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_strb) == 1) || (wr_strb == '1));
   p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, exc_valid}));
endmodule

// File: tb/cbz_store_seq_bench.sv
`timescale 1ns/1ps
module cbz_store_seq_bench;
   localparam int AW  = 32;
   localparam int BLK = 64;
   localparam int WB  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_priv = 2'd3;
   logic          req_virt = 1'b0;
   logic          req_io = 1'b0;
   logic          cfg_m_en = 1'b1, cfg_h_en = 1'b1, cfg_s_en = 1'b1;
   logic          busy, probe_valid, wr_valid, done, exc_valid;
   logic [AW-1:0] probe_addr, wr_addr;
   logic          probe_resp = 1'b0, probe_fault = 1'b0, wr_ready = 1'b0;
   logic [WB-1:0] wr_strb;
   logic [8*WB-1:0] wr_data;
   logic [4:0]    exc_cause;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cbz_store_seq #(.AW(AW), .BLOCK_BYTES(BLK), .WORD_BYTES(WB)) u_cbz_store_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_priv(req_priv), .req_virt(req_virt), .req_io(req_io),
      .cfg_m_en(cfg_m_en), .cfg_h_en(cfg_h_en), .cfg_s_en(cfg_s_en),
      .busy(busy), .probe_valid(probe_valid), .probe_addr(probe_addr),
      .probe_resp(probe_resp), .probe_fault(probe_fault),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
      .wr_ready(wr_ready), .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected trap cause from the requirements; 0 means no trap.
   function automatic int exp_cause(input logic [1:0] pr, input bit v, m, h, s);
      if (pr != 2'd3 && !m) return 2;
      if (v && ((pr <= 2'd1 && !h) || (pr == 2'd0 && !s))) return 22;
      if (!v && pr == 2'd0 && !s) return 2;
      return 0;
   endfunction

   function automatic string exp_tag(input logic [1:0] pr, input bit v, m, h, s);
      if (pr != 2'd3 && !m) return "R1";
      if (v && ((pr <= 2'd1 && !h) || (pr == 2'd0 && !s))) return "R2";
      if (!v && pr == 2'd0 && !s) return "R3";
      return "R4";
   endfunction

   task automatic run_op(input logic [AW-1:0] a, input logic [1:0] pr,
                         input bit v, io, m, h, s, flt, intr);
      int            ec    = exp_cause(pr, v, m, h, s);
      string         tg    = exp_tag(pr, v, m, h, s);
      logic [AW-1:0] base  = a & ~AW'(BLK - 1);
      int            off   = 0;
      int            nwr   = 0;
      int            cyc   = 0;
      int            got_c = -1;
      bit            got_d = 1'b0;
      bit            fin   = 1'b0;
      bit            probed = 1'b0;
      bit            busy_at_done = 1'b0;
      string         wt    = io ? "R9" : "R8";
      req_addr = a; req_priv = pr; req_virt = v; req_io = io;
      cfg_m_en = m; cfg_h_en = h; cfg_s_en = s;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!fin && cyc < 2000) begin
         probe_resp = 1'b0; wr_ready = 1'b0; req_valid = 1'b0;
         if (exc_valid) begin
            got_c = exc_cause; fin = 1'b1;
         end else if (done) begin
            got_d = 1'b1; busy_at_done = busy; fin = 1'b1;
         end else begin
            if (probe_valid) begin
               chk(probe_addr == base, "R6", "probe address", probe_addr, base);
               chk(nwr == 0, "R6", "probe before writes", nwr, 0);
               probe_resp = ($urandom % 3) != 0;
               probe_fault = flt;
               probed = 1'b1;
            end
            if (wr_valid) begin
               logic [AW-1:0] ea = base + AW'(off);
               logic [WB-1:0] es = io ? (WB'(1) << (ea % WB)) : '1;
               chk(wr_addr == ea, wt, "write address", wr_addr, ea);
               chk(wr_strb == es, wt, "write strobe", wr_strb, es);
               chk(wr_data == '0, wt, "write data", wr_data, 0);
               if (intr && nwr == 2) begin
                  // R11: trapping request while busy must be ignored
                  req_valid = 1'b1; req_priv = 2'd0; cfg_m_en = 1'b0;
               end
               wr_ready = ($urandom % 3) != 0;
               if (wr_ready) begin
                  nwr++;
                  off += io ? 1 : WB;
               end
            end
            @(negedge clk);
            cyc++;
         end
      end
      probe_resp = 1'b0; wr_ready = 1'b0; req_valid = 1'b0;
      chk(fin, "R10", "operation finished", cyc, 0);
      if (ec != 0) begin
         chk(got_c == ec, tg, "trap cause", got_c, ec);
         chk(cyc == 0, "R5", "trap latency", cyc, 0);
         chk(!probed && nwr == 0, "R5", "no probe or write on trap", nwr, 0);
      end else if (flt) begin
         chk(got_c == 7, "R7", "probe fault cause", got_c, 7);
         chk(nwr == 0, "R7", "no writes after fault", nwr, 0);
      end else begin
         int beats = io ? BLK : BLK / WB;
         chk(got_d && got_c == -1, "R4", "completes without trap", got_c, -1);
         chk(nwr == beats, wt, "write count", nwr, beats);
         chk(!busy_at_done, "R10", "idle at done", busy_at_done, 0);
         if (intr) chk(got_c == -1 && nwr == beats, "R11", "busy request ignored", got_c, -1);
      end
      @(negedge clk);
      chk(!done && !exc_valid, "R10", "outcome is one cycle", {done, exc_valid}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      chk(!busy && !probe_valid && !wr_valid && !done && !exc_valid, "R12",
          "reset outputs", {busy, probe_valid, wr_valid, done, exc_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed priority corners
      run_op(32'h0000_1234, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R1 over R2
      run_op(32'h0000_1234, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R2 via s_en
      run_op(32'h0000_1234, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R2 via h_en
      run_op(32'h0000_1234, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R3
      run_op(32'h0000_1234, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R4 machine
      run_op(32'hdead_beef, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R4 S no virt
      run_op(32'h0000_107f, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R9 io
      run_op(32'h0000_2001, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R7
      run_op(32'h0000_3fc0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); // R11
      for (int i = 0; i < 80; i++) begin
         logic [1:0] pr;
         int sel = $urandom % 3;
         pr = (sel == 0) ? 2'd0 : (sel == 1) ? 2'd1 : 2'd3;
         run_op($urandom, pr, 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0),
                1'($urandom % 4 != 0), 1'($urandom % 4 != 0), 1'($urandom % 5 == 0),
                1'($urandom % 6 == 0));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule